// File: doc/BRIEF.md
# Host-to-Slave Parallel Transfer Endpoint

This block is the slave-side end of a parallel link from a host computer to a detachable slave processor. The host drives a 16-bit data bus toward the slave, reads a 16-bit bus coming back, pulses a strobe to latch a 4-bit command, and moves words with an asynchronous request/acknowledge pair. The endpoint performs each word transfer itself as a direct access to the slave's local memory. Before driving that memory it requests the bus from the local processor and waits for a grant.

The host first latches a command. Address-set, single-word read or write, and block read or write commands then act on each request that follows, until the host latches a different command. Halt and run commands switch the slave processor's run line, because the slave has no front panel of its own. The memory sits outside the block and has a single read-write port with a read latency of one cycle.

Top module: `slave_link_ep`

## Requirements
- R1: After reset, `ack`, `bus_req`, `mem_we`, `mem_re` and `cpu_run` are 0, and `cmd_q` holds 0 (no-op).
- R2: On a rising edge of the synchronized `cmd_stb`, a code from 0 to 7 on `cmd_in` is copied to `cmd_q`. The codes are: 0 no-op, 1 set address, 2 write word, 3 read word, 4 block write, 5 block read, 6 halt, 7 run. Codes 8 to 15 leave `cmd_q` unchanged.
- R3: While `cmd_q` is 0, 6 or 7, a request gets no `ack`, and no memory strobe or `bus_req` is issued.
- R4: With command 1, the low 12 bits of the word on `h2s_data` load the address pointer. The transfer is acknowledged without any memory access.
- R5: Command 2 writes the host word to memory at the pointer and leaves the pointer unchanged.
- R6: Command 3 reads memory at the pointer and presents the word on `s2h_data` while `ack` is high. The pointer is left unchanged.
- R7: Commands 4 and 5 transfer one word per request at the pointer, then increment the pointer. The pointer wraps from its highest value to 0.
- R8: `ack` rises only after the memory cycle has completed, stays high while `req` is high, and falls after `req` falls. The next transfer starts only after that (four-phase handshake).
- R9: `bus_req` is raised before any memory strobe, and `mem_we`/`mem_re` are asserted only while `bus_gnt` is high.
- R10: Latching command 6 clears `cpu_run` and latching command 7 sets it. No other command changes `cpu_run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cmd_stb | input | 1 | Asynchronous command strobe from the host |
| cmd_in | input | 4 | Command code, stable while the strobe is high |
| req | input | 1 | Asynchronous transfer request from the host |
| ack | output | 1 | Transfer acknowledge to the host |
| h2s_data | input | 16 | Host-to-slave data word |
| s2h_data | output | 16 | Slave-to-host data word |
| cmd_q | output | 4 | Currently latched command |
| cpu_run | output | 1 | Run enable for the slave processor |
| bus_req | output | 1 | Memory bus request to the local processor |
| bus_gnt | input | 1 | Memory bus grant from the local processor |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data returns one cycle later |
| mem_rdata | input | 16 | Memory read data |

## Verification
The bench builds the block with a 4-bit address, so its 16-word memory can be swept end to end. Block transfers cross the wrap from 15 to 0, and a single write lands at every address. The bench's grant model adds a delay that varies from one transfer to the next, so strobes are checked against late grants as well as immediate ones. All 16 command codes are strobed, which covers both the legal and the reserved values.

// File: rtl/slave_link_ep.sv
module slave_link_ep #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_stb,
  input  logic [CW-1:0] cmd_in,
  input  logic          req,
  output logic          ack,
  input  logic [DW-1:0] h2s_data,
  output logic [DW-1:0] s2h_data,
  output logic [CW-1:0] cmd_q,
  output logic          cpu_run,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [CW-1:0] C_NOP  = CW'(0);
  localparam logic [CW-1:0] C_SETA = CW'(1);
  localparam logic [CW-1:0] C_WR   = CW'(2);
  localparam logic [CW-1:0] C_RD   = CW'(3);
  localparam logic [CW-1:0] C_BWR  = CW'(4);
  localparam logic [CW-1:0] C_BRD  = CW'(5);
  localparam logic [CW-1:0] C_HALT = CW'(6);
  localparam logic [CW-1:0] C_RUN  = CW'(7);

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_READ, S_ACK} st_t;
  st_t st;

  logic req_m, req_s, stb_m, stb_s, stb_d;
  logic [AW-1:0] ptr;
  logic [DW-1:0] dreg;

  wire xfer_ok = (cmd_q >= C_SETA) && (cmd_q <= C_BRD);
  wire is_wr   = (cmd_q == C_WR) || (cmd_q == C_BWR);
  wire is_blk  = (cmd_q == C_BWR) || (cmd_q == C_BRD);
  wire [AW-1:0] ptr_nx = is_blk ? ptr + AW'(1) : ptr;

  assign ack       = (st == S_ACK);
  assign bus_req   = (st == S_BUS) || (st == S_READ);
  assign mem_we    = (st == S_BUS) && bus_gnt && is_wr;
  assign mem_re    = (st == S_BUS) && bus_gnt && !is_wr;
  assign mem_addr  = ptr;
  assign mem_wdata = dreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {req_m, req_s} <= '0;
      {stb_m, stb_s, stb_d} <= '0;
    end else begin
      {req_m, req_s} <= {req, req_m};
      {stb_m, stb_s, stb_d} <= {cmd_stb, stb_m, stb_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= C_NOP;
      cpu_run <= 1'b0;
    end else if (stb_s && !stb_d && cmd_in <= C_RUN) begin
      cmd_q <= cmd_in;
      if (cmd_in == C_HALT) cpu_run <= 1'b0;
      if (cmd_in == C_RUN)  cpu_run <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      dreg     <= '0;
      s2h_data <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (req_s && xfer_ok) begin
            dreg <= h2s_data;
            if (cmd_q == C_SETA) begin
              ptr <= h2s_data[AW-1:0];
              st  <= S_ACK;
            end else begin
              st <= S_BUS;
            end
          end
        S_BUS:
          if (bus_gnt) begin
            if (is_wr) begin
              ptr <= ptr_nx;
              st  <= S_ACK;
            end else begin
              st <= S_READ;
            end
          end
        S_READ: begin
          s2h_data <= mem_rdata;
          ptr      <= ptr_nx;
          st       <= S_ACK;
        end
        S_ACK:
          if (!req_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slave_link_ep_chk.sv
module slave_link_ep_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          ack,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_we,
  input logic          mem_re,
  input logic [CW-1:0] cmd_q
);
  p_ack_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> req);
  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req) |=> ack);
  p_we_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bus_gnt && bus_req));
  p_re_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (bus_gnt && bus_req));
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q <= CW'(7));
  p_no_ack_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CW'(0) && !ack) |=> !ack);
endmodule

bind slave_link_ep slave_link_ep_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .mem_we(mem_we), .mem_re(mem_re), .cmd_q(cmd_q)
);

// File: tb/slave_link_ep_test.sv
module slave_link_ep_test;
  localparam int TCLK = 10;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int CW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cmd_stb = 0, req = 0, bus_gnt = 0;
  logic [CW-1:0] cmd_in = '0;
  logic [DW-1:0] h2s_data = '0, mem_rdata = '0;
  logic ack, cpu_run, bus_req, mem_we, mem_re;
  logic [DW-1:0] s2h_data, mem_wdata;
  logic [CW-1:0] cmd_q;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] mem [DEPTH];
  int errors = 0, checks = 0, cyc = 0, gnt_dly = 0, gcnt = 0;
  int n_we = 0, n_re = 0;
  logic early_strobe = 0;

  always #(TCLK/2) clk = ~clk;

  slave_link_ep #(.DW(DW), .AW(AW), .CW(CW)) uut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin mem[mem_addr] <= mem_wdata; n_we <= n_we + 1; end
    if (mem_re) begin mem_rdata <= mem[mem_addr]; n_re <= n_re + 1; end
    if ((mem_we || mem_re) && !bus_req) early_strobe <= 1;
  end

  always @(negedge clk) begin
    if (!bus_req) begin gcnt <= 0; bus_gnt <= 0; end
    else if (gcnt >= gnt_dly) bus_gnt <= 1;
    else gcnt <= gcnt + 1;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [CW-1:0] c);
    @(negedge clk); cmd_in = c; cmd_stb = 1;
    waitn(4); cmd_stb = 0; waitn(4);
  endtask

  task automatic xfer(input logic [DW-1:0] d, output logic [DW-1:0] rd);
    int t;
    @(negedge clk); h2s_data = d; req = 1;
    t = 0;
    while (!ack && t < 100) begin @(negedge clk); t++; end
    if (!ack) chk("R8 ack timeout", 0, 1);
    rd = s2h_data;
    waitn(3);
    chk("R8 ack held while req high", ack, 1);
    req = 0;
    t = 0;
    while (ack && t < 100) begin @(negedge clk); t++; end
    chk("R8 ack falls after req", ack, 0);
    gnt_dly = (gnt_dly + 1) % 4;
  endtask

  initial begin
    logic [DW-1:0] rd;
    int we0, re0;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    waitn(3);
    chk("R1 ack", ack, 0); chk("R1 bus_req", bus_req, 0);
    chk("R1 cpu_run", cpu_run, 0); chk("R1 cmd_q", cmd_q, 0);
    chk("R1 strobes", {mem_we, mem_re}, 0);
    @(negedge clk); rst_n = 1; waitn(2);

    // R3: request under no-op is ignored
    we0 = n_we; re0 = n_re;
    @(negedge clk); req = 1; waitn(20);
    chk("R3 no ack under nop", ack, 0);
    chk("R3 no bus_req under nop", bus_req, 0);
    req = 0; waitn(4);
    chk("R3 no memory access", n_we + n_re, we0 + re0);

    // R2 / R10: legal codes latch, reserved are dropped
    for (int c = 0; c < 8; c++) begin
      send_cmd(CW'(c));
      chk("R2 latch legal code", cmd_q, c);
      if (c == 6) chk("R10 halt clears run", cpu_run, 0);
      if (c == 7) chk("R10 run sets run", cpu_run, 1);
    end
    for (int c = 8; c < 16; c++) begin
      send_cmd(CW'(c));
      chk("R2 reserved ignored", cmd_q, 7);
      chk("R10 reserved keeps run", cpu_run, 1);
    end
    send_cmd(CW'(2));
    chk("R10 other cmd keeps run", cpu_run, 1);
    send_cmd(CW'(6));
    chk("R10 halt", cpu_run, 0);

    // R3: halt as command blocks transfers
    we0 = n_we; re0 = n_re;
    @(negedge clk); req = 1; waitn(20);
    chk("R3 no ack under halt", ack, 0);
    req = 0; waitn(4);
    chk("R3 no access under halt", n_we + n_re, we0 + re0);

    // R4 + R5: single writes to every address
    for (int a = 0; a < DEPTH; a++) begin
      send_cmd(CW'(1));
      we0 = n_we;
      xfer(DW'(a), rd);
      chk("R4 set address no access", n_we, we0);
      send_cmd(CW'(2));
      xfer(DW'(16'hA000 + a * 3), rd);
      xfer(DW'(16'hB000 + a), rd);
      chk("R5 write lands", mem[a], 16'hB000 + a);
      if (a + 1 < DEPTH) chk("R5 pointer held", mem[a + 1], 0);
    end

    // R6: single reads, pointer held
    for (int a = 0; a < DEPTH; a += 5) begin
      send_cmd(CW'(1)); xfer(DW'(a), rd);
      send_cmd(CW'(3));
      xfer('0, rd); chk("R6 read word", rd, 16'hB000 + a);
      xfer('0, rd); chk("R6 pointer held", rd, 16'hB000 + a);
    end

    // R7: block write across wrap, then block read back
    send_cmd(CW'(1)); xfer(DW'(DEPTH - 3), rd);
    send_cmd(CW'(4));
    for (int k = 0; k < 6; k++) xfer(DW'(16'h5500 + k), rd);
    for (int k = 0; k < 6; k++)
      chk("R7 block write wraps", mem[(DEPTH - 3 + k) % DEPTH], 16'h5500 + k);
    send_cmd(CW'(1)); xfer(DW'(DEPTH - 3), rd);
    send_cmd(CW'(5));
    for (int k = 0; k < 6; k++) begin
      xfer('0, rd);
      chk("R7 block read wraps", rd, 16'h5500 + k);
    end
    // full-depth block read from 0
    send_cmd(CW'(1)); xfer('0, rd);
    send_cmd(CW'(5));
    for (int k = 0; k < DEPTH + 1; k++) begin
      xfer('0, rd);
      chk("R7 full sweep", rd, mem[k % DEPTH]);
    end

    chk("R9 no strobe without bus_req", early_strobe, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule